// File: doc/BRIEF.md
# Macro Program Upload Controller

This block sits on the method-write path of a command front end. It watches each register write event, which carries a method number, a 32-bit value and a count of the parameters still to come in the current burst. It picks out the writes that load macro programs into a code store. One method opens an upload by naming the entry that is being loaded. A second method carries one code word per write.

Each accepted code word goes straight out on a word-write port one cycle later. The port carries a storage key and a word index. The key is the trigger address that will later start the macro: twice the entry number plus 0xE00, taken modulo 2^32. When a code word arrives with a remaining count of zero, the upload closes. A commit strobe then reports the key and the number of words. The code store treats that strobe as the point where the program becomes valid, and it replaces whatever that key held before.

Errors are reported as two sticky flags. One flags code words that arrive while no entry is open. The other flags uploads that run past the fixed staging depth. Execution of the stored macros belongs to a different block.

Top module: `macro_upload`

## Requirements
- R1: After reset all outputs are low and no entry is open, so a code word sent before any entry select is dropped.
- R2: A write to method 0x47 opens an upload for the entry given by its value and restarts the word index at 0. It produces no word write and no commit.
- R3: A write to method 0x46 while an entry is open drives wr_en high in the next cycle. wr_word carries the value, wr_index counts 0, 1, 2, … within the upload, and wr_key = (entry*2 + 0xE00) mod 2^32.
- R4: A 0x46 write with in_remain equal to 0 closes the upload. In the next cycle commit_valid pulses with commit_key equal to the upload's key and commit_len equal to the number of words written in it.
- R5: After any closing write the entry returns to the invalid value 0xFFFFFFFF, so a later code word is not written.
- R6: A code word that arrives while the entry is 0xFFFFFFFF is dropped, with no write and no commit, and sets err_orphan, which stays set until reset. This includes the case where 0xFFFFFFFF was selected explicitly.
- R7: Code words beyond DEPTH (16) in one upload are not written and set err_overflow, which stays set until reset. That upload produces no commit, and the next entry select clears the block.
- R8: An entry select made during an upload discards the words staged so far. Indexing and length restart for the new entry.
- R9: Methods other than 0x46 and 0x47 produce no write, no commit and no error, and leave the open upload unchanged.
- R10: A second upload to the same entry commits again under the same key with its own length.
- R11: Cycles with in_valid low change nothing, whatever the method lines carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A method write event is present |
| in_method | input | 12 | Method number of the write |
| in_value | input | 32 | Value of the write |
| in_remain | input | 16 | Parameters still to follow in the burst |
| wr_en | output | 1 | Code word write strobe |
| wr_key | output | 32 | Storage key (trigger address) of the word |
| wr_index | output | 4 | Word position within the macro |
| wr_word | output | 32 | Code word |
| commit_valid | output | 1 | Macro committed |
| commit_key | output | 32 | Key of the committed macro |
| commit_len | output | 5 | Word count of the committed macro |
| err_orphan | output | 1 | Sticky: code word with no entry open |
| err_overflow | output | 1 | Sticky: upload longer than the staging depth |

## Verification
Uploads of one word and of several words show that index counting and length reporting agree. A mid-upload reselect shows that staged words are discarded rather than appended. Foreign methods and idle cycles placed inside an open upload reveal any stray state change, because the following words must keep their indices. An over-long upload followed by a clean retry of the same entry tells a blocked commit apart from a stuck block, and confirms replacement under the same key. Entry values near the top of the 32-bit range test the key wrap and the explicitly selected invalid entry.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] ENTRY_NONE = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_ENTRY = 2'd1,
    K_CODE  = 2'd2
  } kind_e;
endpackage

// File: rtl/mu_decode.sv
module mu_decode
  import mu_pkg::*;
#(
  parameter int unsigned METHOD_W = 12,
  parameter logic [METHOD_W-1:0] ENTRY_METHOD = 12'h047,
  parameter logic [METHOD_W-1:0] CODE_METHOD  = 12'h046
) (
  input  logic                valid_i,
  input  logic [METHOD_W-1:0] method_i,
  output kind_e               kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if (valid_i) begin
      if (method_i == ENTRY_METHOD)     kind_o = K_ENTRY;
      else if (method_i == CODE_METHOD) kind_o = K_CODE;
    end
  end
endmodule

// File: rtl/mu_track.sv
module mu_track
  import mu_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned REM_W = 16,
  parameter logic [WORD_W-1:0] TRIGGER_BASE = 32'h0000_0E00,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind_i,
  input  logic [WORD_W-1:0] value_i,
  input  logic [REM_W-1:0]  remain_i,
  output logic              wr_fire_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [WORD_W-1:0] key_o,
  output logic              cm_fire_o,
  output logic [CNT_W-1:0]  cm_len_o,
  output logic              orphan_fire_o,
  output logic              ovf_fire_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [WORD_W-1:0] entry_q, entry_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              blk_q, blk_d;
  logic              st_en;
  logic              open_w;

  assign open_w = (entry_q != ENTRY_NONE);
  assign st_en  = (kind_i != K_NONE);
  assign key_o  = (entry_q << 1) + TRIGGER_BASE;

  always_comb begin
    entry_d       = entry_q;
    cnt_d         = cnt_q;
    blk_d         = blk_q;
    wr_fire_o     = 1'b0;
    wr_idx_o      = cnt_q[IDX_W-1:0];
    cm_fire_o     = 1'b0;
    cm_len_o      = cnt_q + CNT_W'(1);
    orphan_fire_o = 1'b0;
    ovf_fire_o    = 1'b0;
    case (kind_i)
      K_ENTRY: begin
        entry_d = value_i;
        cnt_d   = '0;
        blk_d   = 1'b0;
      end
      K_CODE: begin
        if (!open_w) begin
          orphan_fire_o = 1'b1;
        end else begin
          if (cnt_q < DEPTH_C) begin
            wr_fire_o = 1'b1;
            cnt_d     = cnt_q + CNT_W'(1);
          end else begin
            ovf_fire_o = 1'b1;
          end
          if (remain_i == '0) begin
            cm_fire_o = !blk_q && !ovf_fire_o;
            entry_d   = ENTRY_NONE;
            cnt_d     = '0;
            blk_d     = 1'b0;
          end else if (ovf_fire_o) begin
            blk_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= ENTRY_NONE;
      cnt_q   <= '0;
      blk_q   <= 1'b0;
    end else if (st_en) begin
      entry_q <= entry_d;
      cnt_q   <= cnt_d;
      blk_q   <= blk_d;
    end
  end

  // R7: a word index handed out never exceeds the staging depth
  p_index_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire_o |-> (cnt_q < DEPTH_C));
  // R6: no write can come from a closed upload
  p_closed_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !open_w |-> !wr_fire_o && !cm_fire_o);
endmodule

// File: rtl/mu_emit.sv
module mu_emit
  import mu_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] key_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cm_fire_i,
  input  logic [CNT_W-1:0]  cm_len_i,
  input  logic              orphan_fire_i,
  input  logic              ovf_fire_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_key_o,
  output logic [IDX_W-1:0]  wr_index_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic              commit_valid_o,
  output logic [WORD_W-1:0] commit_key_o,
  output logic [CNT_W-1:0]  commit_len_o,
  output logic              err_orphan_o,
  output logic              err_overflow_o
);
  logic orphan_d, overflow_d;

  assign orphan_d   = err_orphan_o | orphan_fire_i;
  assign overflow_d = err_overflow_o | ovf_fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o        <= 1'b0;
      commit_valid_o <= 1'b0;
      err_orphan_o   <= 1'b0;
      err_overflow_o <= 1'b0;
    end else begin
      wr_en_o        <= wr_fire_i;
      commit_valid_o <= cm_fire_i;
      err_orphan_o   <= orphan_d;
      err_overflow_o <= overflow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_key_o   <= '0;
      wr_index_o <= '0;
      wr_word_o  <= '0;
    end else if (wr_fire_i) begin
      wr_key_o   <= key_i;
      wr_index_o <= wr_idx_i;
      wr_word_o  <= word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_key_o <= '0;
      commit_len_o <= '0;
    end else if (cm_fire_i) begin
      commit_key_o <= key_i;
      commit_len_o <= cm_len_i;
    end
  end

  // R6: orphan flag is sticky
  p_orphan_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_orphan_o |=> err_orphan_o);
  // R7: overflow flag is sticky
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow_o |=> err_overflow_o);
endmodule

// File: rtl/macro_upload.sv
module macro_upload
  import mu_pkg::*;
#(
  parameter int unsigned METHOD_W = 12,
  parameter int unsigned REM_W    = 16,
  parameter int unsigned DEPTH    = 16,
  parameter logic [METHOD_W-1:0] ENTRY_METHOD = 12'h047,
  parameter logic [METHOD_W-1:0] CODE_METHOD  = 12'h046,
  parameter logic [31:0] TRIGGER_BASE = 32'h0000_0E00,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [METHOD_W-1:0] in_method,
  input  logic [31:0]         in_value,
  input  logic [REM_W-1:0]    in_remain,
  output logic                wr_en,
  output logic [31:0]         wr_key,
  output logic [IDX_W-1:0]    wr_index,
  output logic [31:0]         wr_word,
  output logic                commit_valid,
  output logic [31:0]         commit_key,
  output logic [CNT_W-1:0]    commit_len,
  output logic                err_orphan,
  output logic                err_overflow
);
  kind_e             kind;
  logic              wr_fire, cm_fire, orphan_fire, ovf_fire;
  logic [IDX_W-1:0]  wr_idx;
  logic [CNT_W-1:0]  cm_len;
  logic [WORD_W-1:0] key;

  mu_decode #(
    .METHOD_W    (METHOD_W),
    .ENTRY_METHOD(ENTRY_METHOD),
    .CODE_METHOD (CODE_METHOD)
  ) u_decode (
    .valid_i (in_valid),
    .method_i(in_method),
    .kind_o  (kind)
  );

  mu_track #(
    .DEPTH       (DEPTH),
    .REM_W       (REM_W),
    .TRIGGER_BASE(TRIGGER_BASE)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind_i       (kind),
    .value_i      (in_value),
    .remain_i     (in_remain),
    .wr_fire_o    (wr_fire),
    .wr_idx_o     (wr_idx),
    .key_o        (key),
    .cm_fire_o    (cm_fire),
    .cm_len_o     (cm_len),
    .orphan_fire_o(orphan_fire),
    .ovf_fire_o   (ovf_fire)
  );

  mu_emit #(
    .IDX_W(IDX_W),
    .CNT_W(CNT_W)
  ) u_emit (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_fire_i     (wr_fire),
    .wr_idx_i      (wr_idx),
    .key_i         (key),
    .word_i        (in_value),
    .cm_fire_i     (cm_fire),
    .cm_len_i      (cm_len),
    .orphan_fire_i (orphan_fire),
    .ovf_fire_i    (ovf_fire),
    .wr_en_o       (wr_en),
    .wr_key_o      (wr_key),
    .wr_index_o    (wr_index),
    .wr_word_o     (wr_word),
    .commit_valid_o(commit_valid),
    .commit_key_o  (commit_key),
    .commit_len_o  (commit_len),
    .err_orphan_o  (err_orphan),
    .err_overflow_o(err_overflow)
  );

  // R2: an entry select never yields a write or a commit
  p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method == ENTRY_METHOD) |=> !wr_en && !commit_valid);
  // R4: a commit coincides with the closing word of the same key and position
  p_commit_with_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> wr_en && (wr_key == commit_key)
                     && (commit_len == CNT_W'(wr_index) + CNT_W'(1)));
  // R9: foreign methods are ignored
  p_foreign_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method != ENTRY_METHOD && in_method != CODE_METHOD)
      |=> !wr_en && !commit_valid && $stable(err_orphan) && $stable(err_overflow));
  // R11: idle cycles change nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en && !commit_valid && $stable(err_orphan) && $stable(err_overflow));
endmodule

// File: tb/macro_upload_tb.sv
`timescale 1ns/1ps
module macro_upload_tb;
  localparam int DEPTH = 16;
  localparam logic [11:0] M_ENTRY = 12'h047;
  localparam logic [11:0] M_CODE  = 12'h046;
  localparam logic [31:0] NONE    = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_method;
  logic [31:0] in_value;
  logic [15:0] in_remain;
  logic        wr_en, commit_valid, err_orphan, err_overflow;
  logic [31:0] wr_key, wr_word, commit_key;
  logic [3:0]  wr_index;
  logic [4:0]  commit_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_entry;
  int          m_cnt;
  bit          m_blk;
  bit          e_wr, e_cm, e_eo, e_ev;
  int          e_idx, e_len;
  logic [31:0] e_key, e_data, e_ck;

  always #10 clk = ~clk;

  macro_upload u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_method(in_method),
    .in_value(in_value), .in_remain(in_remain), .wr_en(wr_en), .wr_key(wr_key),
    .wr_index(wr_index), .wr_word(wr_word), .commit_valid(commit_valid),
    .commit_key(commit_key), .commit_len(commit_len), .err_orphan(err_orphan),
    .err_overflow(err_overflow)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    bit ov;
    e_wr = 1'b0;
    e_cm = 1'b0;
    if (in_valid && in_method == M_ENTRY) begin
      m_entry = in_value; m_cnt = 0; m_blk = 1'b0;
    end else if (in_valid && in_method == M_CODE) begin
      if (m_entry == NONE) e_eo = 1'b1;
      else begin
        ov = 1'b0;
        if (m_cnt < DEPTH) begin
          e_wr = 1'b1; e_idx = m_cnt; e_key = m_entry * 2 + 32'hE00; e_data = in_value;
          m_cnt++;
        end else begin
          ov = 1'b1; e_ev = 1'b1;
        end
        if (in_remain == 0) begin
          if (!m_blk && !ov) begin
            e_cm = 1'b1; e_len = m_cnt; e_ck = m_entry * 2 + 32'hE00;
          end
          m_entry = NONE; m_cnt = 0; m_blk = 1'b0;
        end else if (ov) m_blk = 1'b1;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "wr_en", wr_en, e_wr);
    if (e_wr && wr_en) begin
      chk(tag, "wr_index", wr_index, e_idx);
      chk(tag, "wr_key", wr_key, e_key);
      chk(tag, "wr_word", wr_word, e_data);
    end
    chk(tag, "commit_valid", commit_valid, e_cm);
    if (e_cm && commit_valid) begin
      chk(tag, "commit_key", commit_key, e_ck);
      chk(tag, "commit_len", commit_len, e_len);
    end
    chk(tag, "err_orphan", err_orphan, e_eo);
    chk(tag, "err_overflow", err_overflow, e_ev);
  endtask

  task automatic step(input bit v, input logic [11:0] m, input logic [31:0] val,
                      input logic [15:0] rem, input string tag);
    in_valid = v; in_method = m; in_value = val; in_remain = rem;
    @(posedge clk);
    model();
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic upload(input logic [31:0] ent, input int n, input logic [31:0] seed, input string tag);
    step(1'b1, M_ENTRY, ent, 16'd0, tag);
    for (int i = 0; i < n; i++)
      step(1'b1, M_CODE, seed + 32'(i), 16'(n - 1 - i), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_method = '0; in_value = '0; in_remain = '0;
    m_entry = NONE; m_cnt = 0; m_blk = 1'b0;
    e_wr = 0; e_cm = 0; e_eo = 0; e_ev = 0; e_idx = 0; e_len = 0;
    e_key = '0; e_data = '0; e_ck = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    compare("R1");

    // R2 R3 R4: three-word upload for entry 5, key 0xE0A
    upload(32'd5, 3, 32'hA000_0000, "R3");
    // R5: code word after commit is not written
    step(1'b1, M_CODE, 32'h1234, 16'd0, "R5");

    // R9: foreign methods inside an open upload
    step(1'b1, M_ENTRY, 32'd2, 16'd0, "R2");
    step(1'b1, M_CODE, 32'hB0, 16'd3, "R3");
    step(1'b1, 12'h010, 32'hDEAD, 16'd0, "R9");
    step(1'b1, 12'hE00, 32'hBEEF, 16'd0, "R9");
    // R11: idle cycle carrying a code method
    step(1'b0, M_CODE, 32'hCAFE, 16'd0, "R11");
    step(1'b1, M_CODE, 32'hB1, 16'd1, "R9");
    step(1'b1, M_CODE, 32'hB2, 16'd0, "R4");

    // R8: reselect mid-upload
    step(1'b1, M_ENTRY, 32'd7, 16'd0, "R8");
    step(1'b1, M_CODE, 32'hC0, 16'd5, "R8");
    step(1'b1, M_CODE, 32'hC1, 16'd4, "R8");
    step(1'b1, M_ENTRY, 32'd9, 16'd0, "R8");
    step(1'b1, M_CODE, 32'hC2, 16'd0, "R8");

    // R7: overflow blocks the commit
    upload(32'd1, DEPTH + 2, 32'hD000_0000, "R7");
    // R10: retry of same entry commits under the same key
    upload(32'd1, 2, 32'hE000_0000, "R10");
    // R7: exactly DEPTH words still commits
    upload(32'd3, DEPTH, 32'hF000_0000, "R7");

    // R3: key wraps modulo 2^32
    upload(32'h8000_0000, 1, 32'h55, "R3");
    upload(32'hFFFF_FFFE, 2, 32'h66, "R3");
    // R6: explicitly selected invalid entry drops code
    step(1'b1, M_ENTRY, NONE, 16'd0, "R6");
    step(1'b1, M_CODE, 32'h77, 16'd1, "R6");
    step(1'b1, M_CODE, 32'h78, 16'd0, "R6");
    // R1: a fresh reset clears the sticky flags and closes the entry
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_entry = NONE; m_cnt = 0; m_blk = 1'b0; e_eo = 0; e_ev = 0; e_wr = 0; e_cm = 0;
    compare("R1");
    step(1'b1, M_CODE, 32'h99, 16'd0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule